// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block owns the program counter of a 32-bit load/store core whose branches and jumps act one instruction late. Every cycle the decode stage hands it a transfer class, the two source register values, the 16-bit relative offset, the 26-bit absolute index and the destination register number of the instruction now at the PC. The block decides whether a transfer is taken, computes its target, and writes the return address to the link register when the class asks for it.

A taken transfer does not redirect at once. The instruction that follows it (the delay slot) still executes at PC+4, and only the step after that loads the recorded target. If the recorded target lies below a base address given on an input, the PC goes on to PC+4 and a one-cycle service trap carrying the target is raised for an outside handler. A transfer found in a delay slot is dropped and flagged. A stall input freezes the whole sequencer.

Top module: `dspc_top`

## Requirements
- R1: A synchronous active-high reset sets `pc` to the parameter RESET_PC and clears any pending transfer, so the first instruction after reset goes on to `pc`+4 even if a taken transfer came just before reset.
- R2: With no transfer pending and class 0 (none), or an unknown class 13 to 15, or a conditional branch that is not taken, `pc` advances by 4 on each clock edge that is not stalled.
- R3: Class codes on `xfer_cls` are 0 none, 1 equal, 2 not equal, 3 less-or-equal zero, 4 greater than zero, 5 less than zero, 6 greater-or-equal zero, 7 less than zero with link, 8 greater-or-equal zero with link, 9 absolute jump, 10 absolute jump with link, 11 register jump, 12 register jump with link. After a taken transfer, the next `pc` is the old `pc`+4 (the delay slot), and the step after that loads the target.
- R4: A relative branch target is the branch's `pc`+4 plus the sign-extended `offset` shifted left by 2, modulo 2^32.
- R5: An absolute jump target keeps bits 31:28 of the jump's `pc`+4 and puts `index` shifted left by 2 in bits 27:0.
- R6: A register jump takes its target from `rs_val`; the linking register jump (class 12) writes `pc`+8 to register `rd_addr`.
- R7: Equal and not equal compare `rs_val` with `rt_val`; the four zero tests treat `rs_val` as a signed two's-complement number.
- R8: Classes 7, 8 and 10 write `pc`+8 to register 31 in the cycle they are decoded, whether or not the branch is taken.
- R9: When the recorded target is unsigned-below `base_addr`, the step that would load it goes to `pc`+4 instead and `trap` is high for that one cycle with `trap_addr` equal to the target; a target equal to `base_addr` loads normally.
- R10: A transfer of any class 1 to 12 decoded in a delay slot is ignored (no target change, no link write) and `nest_err` is high in that cycle.
- R11: While `stall` is high, `pc` and the pending state hold, and `link_we`, `trap` and `nest_err` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze the sequencer this cycle |
| xfer_cls | input | 4 | Transfer class of the instruction at `pc` |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| offset | input | 16 | Relative branch offset in words |
| index | input | 26 | Absolute jump word index |
| rd_addr | input | 5 | Link destination for the register jump with link |
| base_addr | input | 32 | Lowest target that is loaded directly |
| pc | output | 32 | Address of the instruction being decoded |
| link_we | output | 1 | Link register write enable |
| link_addr | output | 5 | Link register number |
| link_data | output | 32 | Return address (`pc`+8) |
| trap | output | 1 | Service trap pulse |
| trap_addr | output | 32 | Target that raised the trap |
| nest_err | output | 1 | Transfer found in a delay slot |

## Verification
The bench builds the block twice from the same inputs: once with the default parameters (32-bit word, 16-bit offset, 26-bit index, link register 31, trap path enabled) and once with the trap path removed, which shows that a low target then loads straight into the PC. The full 32-bit width brings the wrap of a relative target past zero in both directions within reach, as well as the top-nibble carry of an absolute jump made from the last word of a 256 MiB region. The base address is driven at 0x400 so that a target exactly on it and one just under it can both be reached from a register jump.

// File: rtl/dspc_pkg.sv
package dspc_pkg;

   typedef enum logic [3:0] {
      XF_NONE     = 4'd0,
      XF_EQ       = 4'd1,
      XF_NE       = 4'd2,
      XF_LEZ      = 4'd3,
      XF_GTZ      = 4'd4,
      XF_LTZ      = 4'd5,
      XF_GEZ      = 4'd6,
      XF_LTZ_LNK  = 4'd7,
      XF_GEZ_LNK  = 4'd8,
      XF_JABS     = 4'd9,
      XF_JABS_LNK = 4'd10,
      XF_JREG     = 4'd11,
      XF_JREG_LNK = 4'd12
   } xfer_e;

   // Target source selected by the decoder.
   typedef enum logic [1:0] {
      TK_REL = 2'd0,
      TK_ABS = 2'd1,
      TK_REG = 2'd2
   } tgt_kind_e;

   // SQ_DELAY only exists inside a cycle: the registered state is
   // either SQ_NORMAL or SQ_JUMP.
   typedef enum logic [1:0] {
      SQ_NORMAL = 2'd0,
      SQ_DELAY  = 2'd1,
      SQ_JUMP   = 2'd2
   } seq_e;

endpackage

// File: rtl/dspc_cond.sv
module dspc_cond
   import dspc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [3:0]      cls,
   input  logic [XLEN-1:0] rs_val,
   input  logic [XLEN-1:0] rt_val,
   output logic            is_xfer,
   output logic            taken,
   output logic            link_fix,
   output logic            link_rd,
   output tgt_kind_e       kind
);

   localparam int SIGN_BIT = XLEN - 1;

   xfer_e code;
   logic  rs_neg;
   logic  rs_zero;
   logic  same;

   assign code    = xfer_e'(cls);
   assign rs_neg  = rs_val[SIGN_BIT];
   assign rs_zero = (rs_val == '0);
   assign same    = (rs_val == rt_val);

   always_comb begin
      is_xfer  = 1'b1;
      taken    = 1'b0;
      link_fix = 1'b0;
      link_rd  = 1'b0;
      kind     = TK_REL;
      case (code)
         XF_EQ:       taken = same;
         XF_NE:       taken = !same;
         XF_LEZ:      taken = rs_neg || rs_zero;
         XF_GTZ:      taken = !rs_neg && !rs_zero;
         XF_LTZ:      taken = rs_neg;
         XF_GEZ:      taken = !rs_neg;
         XF_LTZ_LNK: begin
            taken    = rs_neg;
            link_fix = 1'b1;
         end
         XF_GEZ_LNK: begin
            taken    = !rs_neg;
            link_fix = 1'b1;
         end
         XF_JABS: begin
            taken = 1'b1;
            kind  = TK_ABS;
         end
         XF_JABS_LNK: begin
            taken    = 1'b1;
            kind     = TK_ABS;
            link_fix = 1'b1;
         end
         XF_JREG: begin
            taken = 1'b1;
            kind  = TK_REG;
         end
         XF_JREG_LNK: begin
            taken   = 1'b1;
            kind    = TK_REG;
            link_rd = 1'b1;
         end
         default:     is_xfer = 1'b0;
      endcase
   end

   // R8: the linking zero tests request a fixed-register link in every case
   always_comb begin
      if ((code == XF_LTZ_LNK) || (code == XF_GEZ_LNK)) begin
         p_link_always_r8: assert (link_fix && is_xfer);
      end
   end

   // R7: a negative rs is never greater than zero
   always_comb begin
      if ((code == XF_GTZ) && rs_neg) begin
         p_signed_gtz_r7: assert (!taken);
      end
   end

endmodule

// File: rtl/dspc_target.sv
module dspc_target
   import dspc_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int OFF_W = 16,
   parameter int IDX_W = 26
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [OFF_W-1:0] offset,
   input  logic [IDX_W-1:0] index,
   input  logic [XLEN-1:0]  rs_val,
   input  tgt_kind_e        kind,
   output logic [XLEN-1:0]  pc_step,
   output logic [XLEN-1:0]  ret_addr,
   output logic [XLEN-1:0]  target
);

   localparam int WORD_SH = 2;
   localparam int EXT_W   = XLEN - OFF_W - WORD_SH;
   localparam int HIGH_W  = XLEN - IDX_W - WORD_SH;

   logic [XLEN-1:0] rel_disp;
   logic [XLEN-1:0] rel_tgt;
   logic [XLEN-1:0] abs_tgt;

   assign pc_step  = pc + XLEN'(4);
   assign ret_addr = pc + XLEN'(8);

   generate
      if (EXT_W > 0) begin : g_sext
         assign rel_disp = {{EXT_W{offset[OFF_W-1]}}, offset, {WORD_SH{1'b0}}};
      end else begin : g_nosext
         assign rel_disp = {offset[XLEN-WORD_SH-1:0], {WORD_SH{1'b0}}};
      end
   endgenerate

   assign rel_tgt = pc_step + rel_disp;
   assign abs_tgt = {pc_step[XLEN-1 -: HIGH_W], index, {WORD_SH{1'b0}}};

   always_comb begin
      case (kind)
         TK_ABS:  target = abs_tgt;
         TK_REG:  target = rs_val;
         default: target = rel_tgt;
      endcase
   end

   // R5: an absolute target stays inside the region of the slot instruction
   always_comb begin
      if (kind == TK_ABS) begin
         p_abs_region_r5: assert (target[XLEN-1 -: HIGH_W] == pc_step[XLEN-1 -: HIGH_W]);
      end
   end

   // R4: a relative target is always word aligned when the PC is
   always_comb begin
      if ((kind == TK_REL) && (pc[WORD_SH-1:0] == '0)) begin
         p_rel_align_r4: assert (target[WORD_SH-1:0] == '0);
      end
   end

endmodule

// File: rtl/dspc_seq.sv
module dspc_seq
   import dspc_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] RESET_PC = 'h1000,
   parameter bit              TRAP_EN  = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            stall,
   input  logic            xfer_req,
   input  logic [XLEN-1:0] target,
   input  logic [XLEN-1:0] pc_step,
   input  logic [XLEN-1:0] base_addr,
   output logic [XLEN-1:0] pc,
   output seq_e            state,
   output logic            trap,
   output logic [XLEN-1:0] trap_addr
);

   logic [XLEN-1:0] pend;
   logic [XLEN-1:0] pend_nx;
   logic [XLEN-1:0] pc_nx;
   seq_e            mid;
   seq_e            st_nx;
   logic            below;

   generate
      if (TRAP_EN) begin : g_trap
         assign below = (pend < base_addr);
      end else begin : g_flat
         logic unused_base;
         assign unused_base = ^base_addr;
         assign below       = 1'b0;
      end
   endgenerate

   // In-cycle state: a taken transfer seen in the normal state moves to
   // the delay state before the step is applied.
   assign mid = ((state == SQ_NORMAL) && xfer_req) ? SQ_DELAY : state;

   always_comb begin
      pc_nx   = pc_step;
      pend_nx = pend;
      st_nx   = state;
      case (mid)
         SQ_DELAY: begin
            pend_nx = target;
            st_nx   = SQ_JUMP;
         end
         SQ_JUMP: begin
            st_nx = SQ_NORMAL;
            if (!below) begin
               pc_nx = pend;
            end
         end
         default: st_nx = SQ_NORMAL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc    <= RESET_PC;
         state <= SQ_NORMAL;
         pend  <= '0;
      end else if (!stall) begin
         pc    <= pc_nx;
         state <= st_nx;
         pend  <= pend_nx;
      end
   end

   assign trap      = (state == SQ_JUMP) && !stall && below;
   assign trap_addr = pend;

   // R2: plain advance
   p_step_r2: assert property (@(posedge clk) disable iff (rst)
      (!stall && (state == SQ_NORMAL) && !xfer_req) |=> (pc == $past(pc_step)));

   // R3: a taken transfer still executes its delay slot
   p_slot_r3: assert property (@(posedge clk) disable iff (rst)
      (!stall && (state == SQ_NORMAL) && xfer_req)
      |=> ((state == SQ_JUMP) && (pc == $past(pc_step))));

   // R3: the step after the slot loads the recorded target
   p_load_r3: assert property (@(posedge clk) disable iff (rst)
      (!stall && (state == SQ_JUMP) && !trap)
      |=> ((pc == $past(pend)) && (state == SQ_NORMAL)));

   // R3: the delay state is never held across an edge
   p_no_mid_r3: assert property (@(posedge clk) disable iff (rst)
      (state != SQ_DELAY));

   // R9: the trap lasts one cycle and lets the PC fall through
   p_trap_once_r9: assert property (@(posedge clk) disable iff (rst)
      trap |=> (!trap && (pc == $past(pc_step))));

   // R11: stall holds the sequencer
   p_hold_r11: assert property (@(posedge clk) disable iff (rst)
      stall |=> ($stable(pc) && $stable(state)));

endmodule

// File: rtl/dspc_top.sv
module dspc_top
   import dspc_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          OFF_W    = 16,
   parameter int          IDX_W    = 26,
   parameter int          RA_W     = 5,
   parameter int          LINK_REG = 31,
   parameter logic [31:0] RESET_PC = 32'h0000_1000,
   parameter bit          TRAP_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             stall,
   input  logic [3:0]       xfer_cls,
   input  logic [XLEN-1:0]  rs_val,
   input  logic [XLEN-1:0]  rt_val,
   input  logic [OFF_W-1:0] offset,
   input  logic [IDX_W-1:0] index,
   input  logic [RA_W-1:0]  rd_addr,
   input  logic [XLEN-1:0]  base_addr,
   output logic [XLEN-1:0]  pc,
   output logic             link_we,
   output logic [RA_W-1:0]  link_addr,
   output logic [XLEN-1:0]  link_data,
   output logic             trap,
   output logic [XLEN-1:0]  trap_addr,
   output logic             nest_err
);

   localparam logic [RA_W-1:0] LINK_IDX = RA_W'(LINK_REG);
   localparam logic [XLEN-1:0] RST_VEC  = XLEN'(RESET_PC);

   generate
      if (XLEN < OFF_W + 2) begin : g_bad_off
         $error("dspc_top: XLEN too small for OFF_W");
      end
      if (XLEN <= IDX_W + 2) begin : g_bad_idx
         $error("dspc_top: XLEN must exceed IDX_W + 2");
      end
      if ((LINK_REG < 0) || (LINK_REG >= (1 << RA_W))) begin : g_bad_link
         $error("dspc_top: LINK_REG outside register range");
      end
   endgenerate

   logic            is_xfer;
   logic            taken;
   logic            link_fix;
   logic            link_rd;
   tgt_kind_e       kind;
   logic [XLEN-1:0] pc_step;
   logic [XLEN-1:0] ret_addr;
   logic [XLEN-1:0] target;
   seq_e            state;
   logic            in_normal;

   dspc_cond #(.XLEN(XLEN)) u_cond (
      .cls      (xfer_cls),
      .rs_val   (rs_val),
      .rt_val   (rt_val),
      .is_xfer  (is_xfer),
      .taken    (taken),
      .link_fix (link_fix),
      .link_rd  (link_rd),
      .kind     (kind)
   );

   dspc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
      .pc       (pc),
      .offset   (offset),
      .index    (index),
      .rs_val   (rs_val),
      .kind     (kind),
      .pc_step  (pc_step),
      .ret_addr (ret_addr),
      .target   (target)
   );

   dspc_seq #(.XLEN(XLEN), .RESET_PC(RST_VEC), .TRAP_EN(TRAP_EN)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .stall     (stall),
      .xfer_req  (taken && is_xfer),
      .target    (target),
      .pc_step   (pc_step),
      .base_addr (base_addr),
      .pc        (pc),
      .state     (state),
      .trap      (trap),
      .trap_addr (trap_addr)
   );

   assign in_normal = (state == SQ_NORMAL);
   assign link_we   = !stall && in_normal && (link_fix || link_rd);
   assign link_addr = link_fix ? LINK_IDX : rd_addr;
   assign link_data = ret_addr;
   assign nest_err  = !stall && (state == SQ_JUMP) && is_xfer;

   // R10: a dropped transfer never writes a link
   p_nest_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      nest_err |-> !link_we);

   // R10: a dropped transfer leaves the next PC on the recorded path
   p_nest_keep_r10: assert property (@(posedge clk) disable iff (rst)
      (nest_err && !trap) |=> (state == SQ_NORMAL));

   // R11: no side effects while stalled
   p_stall_quiet_r11: assert property (@(posedge clk) disable iff (rst)
      stall |-> (!link_we && !trap && !nest_err));

   // R6: the return address is two words past the linking instruction
   p_link_pc8_r6: assert property (@(posedge clk) disable iff (rst)
      link_we |=> ($past(link_data) == $past(pc) + XLEN'(8)));

endmodule

// File: tb/dspc_top_test.sv
`timescale 1ns/1ps
module dspc_top_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stall = 1'b0;
   logic [3:0]  xfer_cls = '0;
   logic [31:0] rs_val = '0;
   logic [31:0] rt_val = '0;
   logic [15:0] offset = '0;
   logic [25:0] index = '0;
   logic [4:0]  rd_addr = '0;
   logic [31:0] base_addr = 32'h0000_0400;

   logic [31:0] pc, link_data, trap_addr;
   logic [4:0]  link_addr;
   logic        link_we, trap, nest_err;

   logic [31:0] f_pc, f_link_data, f_trap_addr;
   logic [4:0]  f_link_addr;
   logic        f_link_we, f_trap, f_nest;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   dspc_top uut (
      .clk(clk), .rst(rst), .stall(stall), .xfer_cls(xfer_cls),
      .rs_val(rs_val), .rt_val(rt_val), .offset(offset), .index(index),
      .rd_addr(rd_addr), .base_addr(base_addr), .pc(pc), .link_we(link_we),
      .link_addr(link_addr), .link_data(link_data), .trap(trap),
      .trap_addr(trap_addr), .nest_err(nest_err)
   );

   dspc_top #(.TRAP_EN(1'b0)) uut_flat (
      .clk(clk), .rst(rst), .stall(stall), .xfer_cls(xfer_cls),
      .rs_val(rs_val), .rt_val(rt_val), .offset(offset), .index(index),
      .rd_addr(rd_addr), .base_addr(base_addr), .pc(f_pc), .link_we(f_link_we),
      .link_addr(f_link_addr), .link_data(f_link_data), .trap(f_trap),
      .trap_addr(f_trap_addr), .nest_err(f_nest)
   );

   typedef struct packed {
      logic [3:0]  cls;
      logic [31:0] rs;
      logic [31:0] rt;
      logic [15:0] off;
      logic [25:0] idx;
      logic [4:0]  rd;
      logic [31:0] npc;
      logic        lwe;
      logic [4:0]  la;
      logic [31:0] ld;
      logic        trp;
      logic [31:0] ta;
      logic        nst;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{4'd0,  32'h0,        32'h0, 16'h0,    26'h0,       5'd0, 32'h1004,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R2
      '{4'd1,  32'h5,        32'h5, 16'h0010, 26'h0,       5'd0, 32'h1008,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R3 R7 taken equal
      '{4'd0,  32'h0,        32'h0, 16'h0,    26'h0,       5'd0, 32'h1048,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R4 slot then target
      '{4'd2,  32'h5,        32'h5, 16'h0010, 26'h0,       5'd0, 32'h104C,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R7 not equal fails
      '{4'd3,  32'hFFFFFFFF, 32'h0, 16'hFFFE, 26'h0,       5'd0, 32'h1050,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R7 signed -1 <= 0
      '{4'd0,  32'h0,        32'h0, 16'h0,    26'h0,       5'd0, 32'h1048,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R4 backward
      '{4'd4,  32'h80000000, 32'h0, 16'h0010, 26'h0,       5'd0, 32'h104C,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R7 most negative > 0 fails
      '{4'd7,  32'h1,        32'h0, 16'h0010, 26'h0,       5'd0, 32'h1050,     1'b1, 5'd31, 32'h1054,  1'b0, 32'h0,   1'b0}, // R8 link when not taken
      '{4'd8,  32'h0,        32'h0, 16'h0004, 26'h0,       5'd0, 32'h1054,     1'b1, 5'd31, 32'h1058,  1'b0, 32'h0,   1'b0}, // R8 link when taken
      '{4'd9,  32'h0,        32'h0, 16'h0,    26'h0000100, 5'd0, 32'h1064,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b1}, // R10 nested dropped
      '{4'd10, 32'h0,        32'h0, 16'h0,    26'h0000800, 5'd0, 32'h1068,     1'b1, 5'd31, 32'h106C,  1'b0, 32'h0,   1'b0}, // R5 R8
      '{4'd0,  32'h0,        32'h0, 16'h0,    26'h0,       5'd0, 32'h2000,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R5
      '{4'd12, 32'h3000,     32'h0, 16'h0,    26'h0,       5'd7, 32'h2004,     1'b1, 5'd7,  32'h2008,  1'b0, 32'h0,   1'b0}, // R6 link to rd
      '{4'd0,  32'h0,        32'h0, 16'h0,    26'h0,       5'd0, 32'h3000,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R6 target from rs
      '{4'd11, 32'h200,      32'h0, 16'h0,    26'h0,       5'd0, 32'h3004,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R9 low target
      '{4'd0,  32'h0,        32'h0, 16'h0,    26'h0,       5'd0, 32'h3008,     1'b0, 5'd0,  32'h0,     1'b1, 32'h200, 1'b0}, // R9 trap, fall through
      '{4'd5,  32'h80000000, 32'h0, 16'h8000, 26'h0,       5'd0, 32'h300C,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R4 R7 wrap below zero
      '{4'd0,  32'h0,        32'h0, 16'h0,    26'h0,       5'd0, 32'hFFFE300C, 1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R4
      '{4'd6,  32'h7FFFFFFF, 32'h0, 16'h7FFF, 26'h0,       5'd0, 32'hFFFE3010, 1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R4 R7 wrap past top
      '{4'd0,  32'h0,        32'h0, 16'h0,    26'h0,       5'd0, 32'h0000300C, 1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R4
      '{4'd9,  32'h0,        32'h0, 16'h0,    26'h3FFFFFF, 5'd0, 32'h3010,     1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}, // R5 full index
      '{4'd0,  32'h0,        32'h0, 16'h0,    26'h0,       5'd0, 32'h0FFFFFFC, 1'b0, 5'd0,  32'h0,     1'b0, 32'h0,   1'b0}  // R5
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] c, input logic [31:0] rs, input logic [15:0] off,
                        input logic [25:0] idx, input logic [4:0] rd);
      xfer_cls = c; rs_val = rs; rt_val = '0; offset = off; index = idx; rd_addr = rd;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (2) @(posedge clk);
      #1;
      chk("R1 reset pc", pc, 32'h1000);
      chk("R1 reset link_we", {31'd0, link_we}, 32'd0);
      chk("R1 reset trap", {31'd0, trap}, 32'd0);
      @(negedge clk);
      rst = 1'b0;

      // table walk
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].cls, VEC[i].rs, VEC[i].off, VEC[i].idx, VEC[i].rd);
         rt_val = VEC[i].rt;
         #1;
         chk($sformatf("row %0d link_we", i), {31'd0, link_we}, {31'd0, VEC[i].lwe});
         if (VEC[i].lwe) begin
            chk($sformatf("row %0d link_addr", i), {27'd0, link_addr}, {27'd0, VEC[i].la});
            chk($sformatf("row %0d link_data", i), link_data, VEC[i].ld);
         end
         chk($sformatf("row %0d trap", i), {31'd0, trap}, {31'd0, VEC[i].trp});
         if (VEC[i].trp) chk($sformatf("row %0d trap_addr", i), trap_addr, VEC[i].ta);
         chk($sformatf("row %0d nest_err", i), {31'd0, nest_err}, {31'd0, VEC[i].nst});
         step();
         chk($sformatf("row %0d next pc", i), pc, VEC[i].npc);
         @(negedge clk);
      end

      // R11: a stalled jump with link has no effect
      stall = 1'b1;
      drive(4'd10, 32'h0, 16'h0, 26'h10, 5'd0);
      #1;
      chk("R11 stalled link_we", {31'd0, link_we}, 32'd0);
      step();
      chk("R11 stalled pc hold", pc, 32'h0FFFFFFC);
      @(negedge clk);
      stall = 1'b0;
      #1;
      chk("R5 R8 link data from top of region", link_data, 32'h1000_0004);
      step();
      chk("R3 slot pc", pc, 32'h1000_0000);
      @(negedge clk);
      stall = 1'b1;
      drive(4'd0, 32'h0, 16'h0, 26'h0, 5'd0);
      repeat (2) step();
      chk("R11 pending held under stall", pc, 32'h1000_0000);
      @(negedge clk);
      stall = 1'b0;
      step();
      chk("R5 region carry target", pc, 32'h1000_0040);

      // R9: target equal to base loads normally
      @(negedge clk);
      drive(4'd11, 32'h400, 16'h0, 26'h0, 5'd0);
      step();
      @(negedge clk);
      drive(4'd0, 32'h0, 16'h0, 26'h0, 5'd0);
      #1;
      chk("R9 no trap at base", {31'd0, trap}, 32'd0);
      step();
      chk("R9 base target loaded", pc, 32'h400);

      // R2: unknown class behaves as none
      @(negedge clk);
      drive(4'd14, 32'h0, 16'h0, 26'h0, 5'd0);
      #1;
      chk("R2 unknown class no nest", {31'd0, nest_err}, 32'd0);
      step();
      chk("R2 unknown class advance", pc, 32'h404);

      // R1: reset clears a pending transfer
      @(negedge clk);
      drive(4'd11, 32'h5000, 16'h0, 26'h0, 5'd0);
      step();
      @(negedge clk);
      rst = 1'b1;
      drive(4'd0, 32'h0, 16'h0, 26'h0, 5'd0);
      step();
      @(negedge clk);
      rst = 1'b0;
      step();
      chk("R1 pending cleared", pc, 32'h1004);

      // R9: variant without trap path loads a low target directly
      @(negedge clk);
      rst = 1'b1;
      step();
      @(negedge clk);
      rst = 1'b0;
      drive(4'd11, 32'h200, 16'h0, 26'h0, 5'd0);
      step();
      @(negedge clk);
      drive(4'd0, 32'h0, 16'h0, 26'h0, 5'd0);
      #1;
      chk("R9 trap raised", {31'd0, trap}, 32'd1);
      chk("R9 flat variant no trap", {31'd0, f_trap}, 32'd0);
      step();
      chk("R9 trap falls through", pc, 32'h1008);
      chk("R9 flat variant loads target", f_pc, 32'h200);
      #1;
      chk("R9 trap is one cycle", {31'd0, trap}, 32'd0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule